// File: doc/BRIEF.md
# SIMD Widening Even/Odd Multiplier

This unit multiplies selected lanes of two vector operands and writes exact, double-width products. It takes a source lane width of 8, 16, 32 or 64 bits and picks either the even-numbered lanes (0, 2, 4, ...) or the odd-numbered lanes (1, 3, 5, ...) of both operands. Result lane i is twice the source width, so no product bits are ever lost. In the 64-bit case a single 128-bit product fills the whole result. Each operand lane is extended in one of three ways before the multiply: both signed, both unsigned, or the first operand unsigned with the second signed.

A request is a 1-bit group select plus a 5-bit minor code. Bit 2 of the minor code chooses even or odd, and bits 1:0 choose the source size. Bits 4:3, read together with the group bit, choose the extension mode or mark the request illegal. The result is registered, so it appears one cycle after the request. A small result-state machine drives the flags. Its states are RS_IDLE (nothing issued last cycle), RS_DONE (a legal request completed) and RS_BAD (an illegal request was rejected). Every state takes the same transitions, chosen by the current request: no request goes to RS_IDLE, a legal request goes to RS_DONE, and an illegal request goes to RS_BAD. There is no back-pressure.

Top module: `simd_wmul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` and `op_illegal` are low and `result` is zero.
- R2: Minor bit 2 = 0 selects source lanes 2i of both operands; minor bit 2 = 1 selects source lanes 2i+1.
- R3: Minor bits 1:0 select the source width N: 00 means 8, 01 means 16, 10 means 32 and 11 means 64. Result lane i occupies bits [2N*i +: 2N], and the product is exact with no truncation.
- R4: With group 0 and minor bits 4:3 = 00, both selected lanes are sign-extended before the multiply.
- R5: With group 0 and minor bits 4:3 = 10, both selected lanes are zero-extended before the multiply.
- R6: With group 1 and minor bits 4:3 = 00, the first operand's lane is zero-extended and the second operand's lane is sign-extended.
- R7: At N = 64, the product of lane 0 (even) or lane 1 (odd) forms the full 128-bit result. The high 64 bits go to bits 127:64 and the low 64 bits to bits 63:0.
- R8: A request with `op_valid` high gives its result and flags on the next cycle. A cycle with `op_valid` low leaves both flags low on the next cycle.
- R9: Group 0 with minor bits 4:3 = 01 or 11, and group 1 with minor bits 4:3 other than 00, are illegal. On the next cycle such a request raises `op_illegal`, holds `res_valid` low and sets `result` to zero.
- R10: While `op_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe for this cycle |
| op_grp | input | 1 | Encoding group: 0 = signed/unsigned, 1 = mixed |
| op_minor | input | 5 | Minor code: mode in bits 4:3, odd in bit 2, size in bits 1:0 |
| src_a | input | VEC_W | First operand vector |
| src_b | input | VEC_W | Second operand vector |
| res_valid | output | 1 | Registered result is from a legal request |
| op_illegal | output | 1 | Previous request carried an illegal code |
| result | output | VEC_W | Registered widened products |

## Verification
The bench builds the block with its default 128-bit vector width. At that width all four size codes are reachable, from eight 16-bit result lanes down to a single 128-bit product. The operands carry extreme values such as the most negative lane, all-ones and mixed signs. Each size, mode and parity therefore shows whether the extension was done correctly at the top bit of the lane. The 64-bit cases are checked against hand-computed products that fill both halves of the result.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

    // Operand extension mode
    typedef enum logic [1:0] {
        SM_SS = 2'd0,   // signed x signed
        SM_UU = 2'd1,   // unsigned x unsigned
        SM_US = 2'd2    // unsigned first x signed second
    } sgn_mode_e;

    // Result-state machine
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_DONE = 2'd1,
        RS_BAD  = 2'd2
    } res_state_e;

    // Number of supported source lane sizes (8,16,32,64)
    localparam int NSIZE    = 4;
    localparam int MIN_LANE = 8;

    typedef struct packed {
        logic      legal;
        logic      odd;
        logic [1:0] size;
        sgn_mode_e mode;
    } dec_t;

endpackage

// File: rtl/wmul_decode.sv
module wmul_decode
    import wmul_pkg::*;
(
    input  logic       grp,
    input  logic [4:0] minor,
    output dec_t       dec
);

    always_comb begin
        dec.odd   = minor[2];
        dec.size  = minor[1:0];
        dec.mode  = SM_SS;
        dec.legal = 1'b0;
        unique case ({grp, minor[4:3]})
            3'b000: begin
                dec.legal = 1'b1;
                dec.mode  = SM_SS;
            end
            3'b010: begin
                dec.legal = 1'b1;
                dec.mode  = SM_UU;
            end
            3'b100: begin
                dec.legal = 1'b1;
                dec.mode  = SM_US;
            end
            default: begin
                dec.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wmul_lane.sv
module wmul_lane #(
    parameter int SRC_W = 8
) (
    input  logic [SRC_W-1:0]   a,
    input  logic [SRC_W-1:0]   b,
    input  logic               a_sx,
    input  logic               b_sx,
    output logic [2*SRC_W-1:0] prod
);

    localparam int PW = 2 * SRC_W;

    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] bx;
    logic signed [PW-1:0] full;

    // Extend each operand to the product width; the exact product fits in PW bits
    assign ax   = signed'({{SRC_W{a_sx & a[SRC_W-1]}}, a});
    assign bx   = signed'({{SRC_W{b_sx & b[SRC_W-1]}}, b});
    assign full = ax * bx;
    assign prod = unsigned'(full);

endmodule

// File: rtl/wmul_array.sv
module wmul_array
    import wmul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             odd,
    input  logic [1:0]       size,
    input  sgn_mode_e        mode,
    output logic [VEC_W-1:0] prod
);

    logic a_sx;
    logic b_sx;
    logic [VEC_W-1:0] by_size [NSIZE];

    assign a_sx = (mode == SM_SS);
    assign b_sx = (mode != SM_UU);

    for (genvar s = 0; s < NSIZE; s++) begin : g_size
        localparam int SW = MIN_LANE << s;
        localparam int NL = VEC_W / (2 * SW);
        logic [VEC_W-1:0] packed_res;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [SW-1:0] sel_a;
            logic [SW-1:0] sel_b;
            assign sel_a = odd ? a[(2*l+1)*SW +: SW] : a[(2*l)*SW +: SW];
            assign sel_b = odd ? b[(2*l+1)*SW +: SW] : b[(2*l)*SW +: SW];
            wmul_lane #(.SRC_W(SW)) u_lane (
                .a    (sel_a),
                .b    (sel_b),
                .a_sx (a_sx),
                .b_sx (b_sx),
                .prod (packed_res[l*2*SW +: 2*SW])
            );
        end
        assign by_size[s] = packed_res;
    end

    assign prod = by_size[size];

endmodule

// File: rtl/simd_wmul.sv
module simd_wmul
    import wmul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_grp,
    input  logic [4:0]       op_minor,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             res_valid,
    output logic             op_illegal,
    output logic [VEC_W-1:0] result
);

    dec_t             dec;
    logic [VEC_W-1:0] prod;
    res_state_e       state_q;
    res_state_e       state_d;
    logic [VEC_W-1:0] res_q;

    wmul_decode u_dec (
        .grp   (op_grp),
        .minor (op_minor),
        .dec   (dec)
    );

    wmul_array #(.VEC_W(VEC_W)) u_arr (
        .a    (src_a),
        .b    (src_b),
        .odd  (dec.odd),
        .size (dec.size),
        .mode (dec.mode),
        .prod (prod)
    );

    // Next state: every state takes the same transitions, chosen by the request
    always_comb begin
        state_d = RS_IDLE;
        unique case (state_q)
            RS_IDLE, RS_DONE, RS_BAD: begin
                if (!op_valid)      state_d = RS_IDLE;
                else if (dec.legal) state_d = RS_DONE;
                else                state_d = RS_BAD;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Result register: loads only on a request, cleared by an illegal one
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (op_valid) res_q <= dec.legal ? prod : '0;
    end

    assign res_valid  = (state_q == RS_DONE);
    assign op_illegal = (state_q == RS_BAD);
    assign result     = res_q;

endmodule

// File: rtl/wmul_chk.sv
module wmul_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             res_valid,
    input logic             op_illegal,
    input logic [VEC_W-1:0] result
);

    AST_OP_GIVES_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (res_valid ^ op_illegal)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !op_illegal)); // R8

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> (result == '0)); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, op_illegal})); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result)); // R10

endmodule

bind simd_wmul wmul_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .res_valid  (res_valid),
    .op_illegal (op_illegal),
    .result     (result)
);

// File: tb/simd_wmul_test.sv
module simd_wmul_test;

    localparam int CLK_P = 10;
    localparam int W     = 128;
    localparam int NV    = 10;

    localparam logic [W-1:0] A1 = 128'h8001_7FFF_FF80_0102_F00F_1234_ABCD_5A5A;
    localparam logic [W-1:0] B1 = 128'hFFFF_8000_7F01_80FE_0FF0_9876_0001_C3C3;
    localparam logic [W-1:0] A2 = 128'h8000000000000000_FFFFFFFFFFFFFFFF;
    localparam logic [W-1:0] B2 = 128'hFFFFFFFFFFFFFFFF_8000000000000000;

    // {grp, minor}
    localparam logic [5:0] V_OP [NV] = '{
        6'b0_00000, 6'b0_00101, 6'b0_10010, 6'b0_10111, 6'b1_00001,
        6'b1_00110, 6'b1_00011, 6'b0_00011, 6'b0_00100, 6'b0_10001
    };
    localparam logic [W-1:0] V_A [NV] = '{A1, A1, A1, A1, A1, A1, A2, A2, A2, B1};
    localparam logic [W-1:0] V_B [NV] = '{B1, B1, B1, B1, B1, B1, B2, B2, B2, A1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_grp = 1'b0;
    logic [4:0]   op_minor = '0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         res_valid;
    logic         op_illegal;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    simd_wmul #(.VEC_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_grp(op_grp),
        .op_minor(op_minor), .src_a(src_a), .src_b(src_b),
        .res_valid(res_valid), .op_illegal(op_illegal), .result(result)
    );

    // Reference: extract lanes bit by bit, apply two's-complement offset for signed lanes
    function automatic logic [W-1:0] model(logic grp, logic [4:0] mn,
                                           logic [W-1:0] a, logic [W-1:0] b);
        int n = 8 << mn[1:0];
        int lanes = 64 / n;
        logic [W-1:0] r = '0;
        bit asg = !grp && !mn[4];
        bit bsg = !(!grp && mn[4]);
        for (int i = 0; i < lanes; i++) begin
            int e = 2*i + int'(mn[2]);
            logic signed [W+1:0] x = '0;
            logic signed [W+1:0] y = '0;
            logic signed [W+1:0] p;
            for (int k = 0; k < n; k++) begin
                x[k] = a[e*n+k];
                y[k] = b[e*n+k];
            end
            if (asg && a[e*n+n-1]) x = x - ((W+2)'(1) << n);
            if (bsg && b[e*n+n-1]) y = y - ((W+2)'(1) << n);
            p = x * y;
            for (int k = 0; k < 2*n; k++) r[i*2*n+k] = p[k];
        end
        return r;
    endfunction

    function automatic string mode_tag(logic grp, logic [4:0] mn);
        if (grp)    return "R6";
        if (mn[4])  return "R5";
        return "R4";
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive after a falling edge; the result register loads at the next rising edge
    task automatic issue(logic grp, logic [4:0] mn, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_grp = grp; op_minor = mn; src_a = a; src_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_valid in reset", W'(res_valid), '0);
        chk("R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", W'({res_valid, op_illegal}), '0);

        // Table walk: R2 parity, R3 size, mode per R4/R5/R6
        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] exp;
            exp = model(V_OP[v][5], V_OP[v][4:0], V_A[v], V_B[v]);
            issue(V_OP[v][5], V_OP[v][4:0], V_A[v], V_B[v]);
            chk($sformatf("R2/R3 %s vec%0d", mode_tag(V_OP[v][5], V_OP[v][4:0]), v), result, exp);
            chk($sformatf("R8 res_valid vec%0d", v), W'(res_valid), W'(1));
        end

        // R7: 64-bit hand values
        issue(1'b0, 5'b00011, A2, B2);    // (-1) * (-2^63) = 2^63
        chk("R7 signed 64 even", result, 128'h0000000000000000_8000000000000000);
        issue(1'b0, 5'b10011, A2, A2);    // (2^64-1)^2
        chk("R7 unsigned 64 even", result, 128'hFFFFFFFFFFFFFFFE_0000000000000001);
        issue(1'b1, 5'b00111, A2, B2);    // 2^63 * (-1) = -2^63
        chk("R7 mixed 64 odd", result, 128'hFFFFFFFFFFFFFFFF_8000000000000000);

        // R10 / R8: idle cycles hold the result and drop the flag
        @(negedge clk);
        chk("R10 hold after idle", result, 128'hFFFFFFFFFFFFFFFF_8000000000000000);
        chk("R8 flags idle", W'({res_valid, op_illegal}), '0);

        // R9: illegal codes
        issue(1'b0, 5'b01000, A1, B1);
        chk("R9 illegal flag g0 01", W'({res_valid, op_illegal}), W'(1));
        chk("R9 illegal result", result, '0);
        issue(1'b1, 5'b10000, A1, B1);
        chk("R9 illegal flag g1 10", W'({res_valid, op_illegal}), W'(1));
        issue(1'b0, 5'b11011, A1, B1);
        chk("R9 illegal flag g0 11", W'({res_valid, op_illegal}), W'(1));

        // R5 byte corner: 0xFF * 0xFF unsigned
        issue(1'b0, 5'b10000, {16{8'hFF}}, {16{8'hFF}});
        chk("R5 u8 max", result, {8{16'hFE01}});
        // R4 byte corner: -128 * -128
        issue(1'b0, 5'b00100, {16{8'h80}}, {16{8'h80}});
        chk("R4 s8 min", result, {8{16'h4000}});

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule